// File: doc/BRIEF.md
# Multi-byte I2C bus master

This block runs one addressed transaction on an I2C bus. A transaction moves zero to seven data bytes in a single direction. The user sets a 7-bit target address, a direction bit and a byte count, then pulses a start input while the block reports ready. The block generates the start condition and sends the address byte. It then moves the data bytes. On a write, it asks for each byte and waits until that byte is marked valid. On a read, it announces each received byte with a one-clock pulse. It ends the transaction with a stop condition.

Bit timing comes from a one-clock enable pulse, `tick_i`, that runs at twice the SCL rate. One tick pulls SCL low and moves SDA. The next tick releases SCL and samples SDA. Both bus lines are open-drain. For each line the block has an input sample, an output value that is always low, and a tristate enable. The enable is high to release the line and low to pull it down. The block watches the bus for start and stop conditions sent by other masters. It reports the bus as busy and does not begin a transaction while another master holds the bus.

Top module: `i2c_txn_master`

## Requirements
- R1: After reset and while idle, `ready_o` is 1, `scl_t_o` and `sda_t_o` are 1 (both lines released), and `bus_busy_o`, `data_req_o` and `data_avail_o` are 0.
- R2: A start accepted in idle makes SDA fall while SCL is released. The first byte on the bus is then the address followed by the direction bit (1 = read, 0 = write), MSB first, followed by an acknowledge slot.
- R3: Each SCL period spans two ticks: SCL is pulled low on one tick and released on the next. SDA changes only on ticks, and it changes while SCL is released only to form the single start or the single stop of a transaction. A transaction that clocks B data bytes shows 9*(B+1)+1 falling SCL edges.
- R4: On a write, `data_req_o` is high while the master waits for a byte, and SCL stays released until `data_valid_i` is seen. The byte on `data_i` is captured on the clock where valid is high and is sent MSB first.
- R5: `size_i` sets the number of data bytes, from 0 to 7. With 0, the address byte is followed directly by a stop.
- R6: On a read, each received byte appears on `data_o` together with a one-clock pulse on `data_avail_o`. The master pulls SDA low (ACK) after every byte except the last, and leaves SDA released (NACK) after the last byte.
- R7: If the target leaves SDA high in the acknowledge slot of the address or of any written byte, the master issues a stop and requests no further bytes.
- R8: Every transaction ends with SDA rising while SCL is released, after which `ready_o` returns to 1.
- R9: `bus_busy_o` goes high on a start condition from another master and low on the next stop. While it is high, `ready_o` is 0 and `start_i` has no effect on the lines.
- R10: `scl_o` and `sda_o` are always 0. The block only pulls a line low or releases it.
- R11: `ready_o` is 0 for the whole of a transaction, and a `start_i` pulse during a transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock enable at twice the SCL rate |
| start_i | input | 1 | Begin a transaction when ready |
| rnw_i | input | 1 | Direction: 1 read, 0 write |
| addr_i | input | 7 | Target address |
| size_i | input | 3 | Number of data bytes (0 to 7) |
| data_i | input | 8 | Write byte |
| data_valid_i | input | 1 | Write byte on `data_i` is valid |
| ready_o | output | 1 | Idle and free to start |
| bus_busy_o | output | 1 | Another master holds the bus |
| data_req_o | output | 1 | Next write byte wanted |
| data_avail_o | output | 1 | Pulse: read byte on `data_o` |
| data_o | output | 8 | Last received byte |
| scl_i | input | 1 | SCL line sample |
| scl_o | output | 1 | SCL output value (always 0) |
| scl_t_o | output | 1 | SCL tristate enable, 1 releases |
| sda_i | input | 1 | SDA line sample |
| sda_o | output | 1 | SDA output value (always 0) |
| sda_t_o | output | 1 | SDA tristate enable, 1 releases |

## Verification
On every cycle, the assertions check several local rules. SDA moves only on a tick. A fall or rise of SDA under a released SCL comes only from the start or stop states. The lines stay released while idle. A read pulse lasts one clock. A busy bus or a missing valid freezes the controller. Other behaviour spans a whole transaction, and only the bench scenarios against a modelled target can show it. This covers the address and data bit order, the ACK/NACK pattern on reads, and aborting on a NACK at the address or at a chosen write byte. It also covers the exact count of requests, read pulses and SCL edges, and the rejection of start requests from a foreign master or during a transaction.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_XFER, ST_WAIT_WR, ST_STOP_A, ST_STOP_B, ST_STOP_C
  } txn_state_e;

  typedef enum logic [1:0] {K_ADDR, K_WR, K_RD} byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= d_i;
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic own_i,
  output logic sda_s_o,
  output logic busy_o
);
  logic [1:0] lines_s;
  logic       scl_q, sda_q, busy_q;
  logic       start_det, stop_det;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  assign start_det = scl_q && lines_s[1] && sda_q && !lines_s[0];
  assign stop_det  = scl_q && lines_s[1] && !sda_q && lines_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q <= lines_s[1];
      sda_q <= lines_s[0];
      if (stop_det)                busy_q <= 1'b0;
      else if (start_det && !own_i) busy_q <= 1'b1;
    end
  end

  assign sda_s_o = lines_s[0];
  assign busy_o  = busy_q;

  // R9: a stop always frees the bus on the next cycle
  p_stop_frees_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !busy_o);
endmodule

// File: rtl/i2c_txn_fsm.sv
module i2c_txn_fsm
  import i2c_txn_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SIZE_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              data_valid_i,
  input  logic              sda_s_i,
  input  logic              bus_busy_i,
  output logic              ready_o,
  output logic              active_o,
  output logic              data_req_o,
  output logic              data_avail_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              scl_t_o,
  output logic              sda_t_o
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT  = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(BYTE_W - 1);

  txn_state_e        state_q;
  byte_kind_e        kind_q;
  logic              phase_q, rnw_q, scl_t_q, sda_t_q, avail_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] shreg_q, data_q;
  logic [SIZE_W-1:0] remain_q;
  logic              sda_drive;

  // value placed on SDA in the low half of the current bit
  always_comb begin
    if (bit_q == ACK_SLOT) sda_drive = (kind_q == K_RD) ? (remain_q == SIZE_W'(1)) : 1'b1;
    else                   sda_drive = (kind_q == K_RD) ? 1'b1 : shreg_q[BYTE_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= K_ADDR;
      phase_q  <= 1'b0;
      rnw_q    <= 1'b0;
      bit_q    <= '0;
      shreg_q  <= '0;
      remain_q <= '0;
      scl_t_q  <= 1'b1;
      sda_t_q  <= 1'b1;
      data_q   <= '0;
      avail_q  <= 1'b0;
    end else begin
      avail_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i && !bus_busy_i) begin
          shreg_q  <= {addr_i, rnw_i};
          rnw_q    <= rnw_i;
          remain_q <= size_i;
          state_q  <= ST_START;
        end
        ST_START: if (tick_i) begin
          sda_t_q <= 1'b0;
          state_q <= ST_XFER;
          kind_q  <= K_ADDR;
          bit_q   <= '0;
          phase_q <= 1'b0;
        end
        ST_WAIT_WR: if (data_valid_i) begin
          shreg_q <= data_i;
          state_q <= ST_XFER;
          kind_q  <= K_WR;
          bit_q   <= '0;
          phase_q <= 1'b0;
        end
        ST_XFER: if (tick_i) begin
          if (!phase_q) begin
            scl_t_q <= 1'b0;
            sda_t_q <= sda_drive;
            phase_q <= 1'b1;
          end else begin
            scl_t_q <= 1'b1;
            phase_q <= 1'b0;
            if (bit_q != ACK_SLOT) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_s_i};
              bit_q   <= bit_q + BIT_W'(1);
              if (kind_q == K_RD && bit_q == LAST_DATA) begin
                data_q  <= {shreg_q[BYTE_W-2:0], sda_s_i};
                avail_q <= 1'b1;
              end
            end else begin
              bit_q <= '0;
              unique case (kind_q)
                K_ADDR: begin
                  if (sda_s_i || remain_q == '0) state_q <= ST_STOP_A;
                  else if (rnw_q)                kind_q  <= K_RD;
                  else                           state_q <= ST_WAIT_WR;
                end
                K_WR: begin
                  remain_q <= remain_q - SIZE_W'(1);
                  if (sda_s_i || remain_q == SIZE_W'(1)) state_q <= ST_STOP_A;
                  else                                   state_q <= ST_WAIT_WR;
                end
                default: begin
                  remain_q <= remain_q - SIZE_W'(1);
                  if (remain_q == SIZE_W'(1)) state_q <= ST_STOP_A;
                end
              endcase
            end
          end
        end
        ST_STOP_A: if (tick_i) begin
          scl_t_q <= 1'b0;
          sda_t_q <= 1'b0;
          state_q <= ST_STOP_B;
        end
        ST_STOP_B: if (tick_i) begin
          scl_t_q <= 1'b1;
          state_q <= ST_STOP_C;
        end
        ST_STOP_C: if (tick_i) begin
          sda_t_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = (state_q == ST_IDLE) && !bus_busy_i;
  assign active_o     = (state_q != ST_IDLE);
  assign data_req_o   = (state_q == ST_WAIT_WR);
  assign data_avail_o = avail_q;
  assign data_o       = data_q;
  assign scl_t_o      = scl_t_q;
  assign sda_t_o      = sda_t_q;

  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (scl_t_q && sda_t_q));

  p_start_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_t_q && $past(scl_t_q) && $fell(sda_t_q)) |-> ($past(state_q) == ST_START));

  p_stop_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_t_q && $past(scl_t_q) && $rose(sda_t_q)) |-> ($past(state_q) == ST_STOP_C));

  p_sda_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_t_q) |-> $past(tick_i));

  p_scl_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_t_q) |-> $past(tick_i));

  p_hold_no_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_WR && !data_valid_i) |=> (state_q == ST_WAIT_WR && $stable(scl_t_q)));

  p_avail_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_avail_o |=> !data_avail_o);

  p_no_launch_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && bus_busy_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/i2c_txn_master.sv
module i2c_txn_master #(
  parameter int ADDR_W      = 7,
  parameter int SIZE_W      = 3,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              data_valid_i,
  output logic              ready_o,
  output logic              bus_busy_o,
  output logic              data_req_o,
  output logic              data_avail_o,
  output logic [BYTE_W-1:0] data_o,
  input  logic              scl_i,
  output logic              scl_o,
  output logic              scl_t_o,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_t_o
);
  logic sda_s, busy, active;

  i2c_bus_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .own_i  (active),
    .sda_s_o(sda_s),
    .busy_o (busy)
  );

  i2c_txn_fsm #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BYTE_W(BYTE_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .start_i     (start_i),
    .rnw_i       (rnw_i),
    .addr_i      (addr_i),
    .size_i      (size_i),
    .data_i      (data_i),
    .data_valid_i(data_valid_i),
    .sda_s_i     (sda_s),
    .bus_busy_i  (busy),
    .ready_o     (ready_o),
    .active_o    (active),
    .data_req_o  (data_req_o),
    .data_avail_o(data_avail_o),
    .data_o      (data_o),
    .scl_t_o     (scl_t_o),
    .sda_t_o     (sda_t_o)
  );

  assign bus_busy_o = busy;
  assign scl_o      = 1'b0;
  assign sda_o      = 1'b0;
endmodule

// File: tb/i2c_txn_master_tb_top.sv
`timescale 1ns/1ps
module i2c_txn_master_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       start_i = 1'b0;
  logic       rnw_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [2:0] size_i = '0;
  logic [7:0] data_i = '0;
  logic       data_valid_i = 1'b0;
  logic       ready_o, bus_busy_o, data_req_o, data_avail_o;
  logic [7:0] data_o;
  logic       scl_i, scl_o, scl_t_o, sda_i, sda_o, sda_t_o;

  logic oth_scl = 1'b1, oth_sda = 1'b1, slv_sda = 1'b1;
  logic scl_line, sda_line;
  assign scl_line = (scl_t_o ? 1'b1 : scl_o) & oth_scl;
  assign sda_line = (sda_t_o ? 1'b1 : sda_o) & oth_sda & slv_sda;
  assign scl_i = scl_line;
  assign sda_i = sda_line;

  always #10 clk_i = ~clk_i;

  i2c_txn_master dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .rnw_i(rnw_i), .addr_i(addr_i), .size_i(size_i), .data_i(data_i),
    .data_valid_i(data_valid_i), .ready_o(ready_o), .bus_busy_o(bus_busy_o),
    .data_req_o(data_req_o), .data_avail_o(data_avail_o), .data_o(data_o),
    .scl_i(scl_i), .scl_o(scl_o), .scl_t_o(scl_t_o),
    .sda_i(sda_i), .sda_o(sda_o), .sda_t_o(sda_t_o)
  );

  int n_chk = 0, n_err = 0;
  int n_start = 0, n_stop = 0, n_sclfall = 0, n_req = 0, n_avail = 0;
  bit od_bad = 1'b0;
  logic [7:0] exp_wr_q[$];
  logic [7:0] exp_rd_q[$];
  logic [7:0] rb[7];
  logic [7:0] wb[7];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      repeat (3) @(negedge clk_i);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  end

  // bus event counters, sampled away from the active edge
  logic scl_p = 1'b1, sda_p = 1'b1, req_p = 1'b0;
  always @(negedge clk_i) begin
    if (scl_p && scl_line && sda_p && !sda_line) n_start++;
    if (scl_p && scl_line && !sda_p && sda_line) n_stop++;
    if (scl_p && !scl_line) n_sclfall++;
    if (data_req_o && !req_p) n_req++;
    if (scl_o || sda_o) od_bad = 1'b1;
    scl_p = scl_line;
    sda_p = sda_line;
    req_p = data_req_o;
  end

  // scoreboard monitor for read bytes (R6)
  always @(negedge clk_i) begin
    if (data_avail_o) begin
      n_avail++;
      if (exp_rd_q.size() == 0) chk(1'b0, "R6", "unexpected read byte", int'(data_o), -1);
      else begin
        logic [7:0] e;
        e = exp_rd_q.pop_front();
        chk(data_o == e, "R6", "read byte", int'(data_o), int'(e));
      end
    end
  end

  function automatic logic [7:0] pat(input int seed, input int k);
    if (k == 0) return (seed[0]) ? 8'hFF : 8'h00;
    return 8'((k * 53 + seed * 29 + 8'h3C) ^ (k << 4));
  endfunction

  task automatic recv(output logic [7:0] b);
    b = '0;
    for (int k = 0; k < 8; k++) begin
      @(posedge scl_line);
      b = {b[6:0], sda_line};
    end
  endtask

  task automatic slave_run(input logic [6:0] a, input logic rd, input int n,
                           input int nack_at, input int s0);
    logic [7:0] b;
    wait (n_start > s0);
    recv(b);
    chk(b == {a, rd}, "R2", "address byte", int'(b), int'({a, rd}));
    @(negedge scl_line);
    slv_sda = (nack_at == 0);
    if (nack_at == 0) return;
    @(negedge scl_line);
    slv_sda = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (!rd) begin
        logic [7:0] e;
        recv(b);
        e = (exp_wr_q.size() != 0) ? exp_wr_q.pop_front() : 8'hxx;
        chk(b === e, "R4", "written byte", int'(b), int'(e));
        @(negedge scl_line);
        slv_sda = (nack_at == i + 1);
        if (nack_at == i + 1) return;
        @(negedge scl_line);
        slv_sda = 1'b1;
      end else begin
        for (int k = 7; k >= 0; k--) begin
          slv_sda = rb[i][k];
          @(posedge scl_line);
          @(negedge scl_line);
        end
        slv_sda = 1'b1;
        @(posedge scl_line);
        chk(sda_line == (i == n - 1), "R6", "master ack level",
            int'(sda_line), int'(i == n - 1));
        @(negedge scl_line);
      end
    end
  endtask

  task automatic run_txn(input logic [6:0] a, input logic rd, input int n,
                         input int nack_at, input int hold_byte, input int seed);
    int s0, p0, f0, r0, v0, clocked;
    s0 = n_start; p0 = n_stop; f0 = n_sclfall; r0 = n_req; v0 = n_avail;
    clocked = (nack_at == 0) ? 0 : (nack_at > 0) ? nack_at : n;
    for (int k = 0; k < 7; k++) begin
      rb[k] = pat(seed, k);
      wb[k] = pat(seed + 7, k);
    end
    if (rd) for (int k = 0; k < clocked; k++) exp_rd_q.push_back(rb[k]);
    fork
      begin
        int k;
        k = 0;
        @(negedge clk_i);
        addr_i = a; rnw_i = rd; size_i = 3'(n); start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        chk(ready_o == 1'b0, "R11", "ready during transaction", int'(ready_o), 0);
        forever begin
          @(negedge clk_i);
          if (ready_o) break;
          if (data_req_o) begin
            if (k == hold_byte) begin
              repeat (20) @(negedge clk_i);
              start_i = 1'b1;  // R11: ignored mid-transaction
              addr_i = ~a;
              @(negedge clk_i);
              start_i = 1'b0;
              repeat (20) @(negedge clk_i);
              chk(scl_t_o == 1'b1 && data_req_o == 1'b1, "R4", "hold without valid",
                  int'({scl_t_o, data_req_o}), 3);
            end
            data_i = wb[k];
            exp_wr_q.push_back(wb[k]);
            data_valid_i = 1'b1;
            @(negedge clk_i);
            data_valid_i = 1'b0;
            k++;
          end
        end
      end
      slave_run(a, rd, n, nack_at, s0);
    join
    repeat (6) @(negedge clk_i);
    chk(n_start - s0 == 1, "R3", "start conditions", n_start - s0, 1);
    chk(n_stop - p0 == 1, "R8", "stop conditions", n_stop - p0, 1);
    chk(ready_o == 1'b1, "R8", "ready after stop", int'(ready_o), 1);
    chk(n_sclfall - f0 == 9 * (clocked + 1) + 1, "R3", "SCL falling edges",
        n_sclfall - f0, 9 * (clocked + 1) + 1);
    if (rd) begin
      chk(n_avail - v0 == clocked, "R5", "read byte pulses", n_avail - v0, clocked);
      chk(n_req - r0 == 0, "R5", "no write requests on read", n_req - r0, 0);
    end else begin
      chk(n_req - r0 == clocked, (nack_at >= 0) ? "R7" : "R5", "write requests",
          n_req - r0, clocked);
      chk(n_avail - v0 == 0, "R5", "no read pulses on write", n_avail - v0, 0);
    end
    chk(exp_wr_q.size() == 0 || nack_at >= 0, "R4", "write bytes left",
        exp_wr_q.size(), 0);
    chk(exp_rd_q.size() == 0, "R6", "read bytes left", exp_rd_q.size(), 0);
    exp_wr_q.delete();
    repeat (8) @(negedge clk_i);
  endtask

  initial begin
    repeat (120000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o && scl_t_o && sda_t_o, "R1", "idle lines and ready",
        int'({ready_o, scl_t_o, sda_t_o}), 7);
    chk(!bus_busy_o && !data_req_o && !data_avail_o, "R1", "idle flags",
        int'({bus_busy_o, data_req_o, data_avail_o}), 0);

    run_txn(7'h5A, 1'b0, 3, -1, 1, 1);   // write, hold on byte 1 (R4, R11)
    run_txn(7'h23, 1'b1, 4, -1, -1, 2);  // read (R6)
    run_txn(7'h7F, 1'b1, 7, -1, -1, 3);  // maximum read (R5)
    run_txn(7'h41, 1'b0, 7, -1, 0, 4);   // maximum write, hold first byte
    run_txn(7'h11, 1'b0, 0, -1, -1, 5);  // address only (R5)
    run_txn(7'h33, 1'b1, 2, 0, -1, 6);   // address NACK (R7)
    run_txn(7'h2C, 1'b0, 4, 2, -1, 7);   // NACK on second write byte (R7)

    // R9: foreign master holds the bus
    @(negedge clk_i);
    oth_sda = 1'b0;
    repeat (6) @(negedge clk_i);
    chk(bus_busy_o == 1'b1 && ready_o == 1'b0, "R9", "busy while foreign",
        int'({bus_busy_o, ready_o}), 2);
    addr_i = 7'h15; rnw_i = 1'b0; size_i = 3'd1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(scl_t_o && sda_t_o, "R9", "start ignored on busy bus",
        int'({scl_t_o, sda_t_o}), 3);
    oth_sda = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(bus_busy_o == 1'b0 && ready_o == 1'b1, "R9", "bus freed by stop",
        int'({bus_busy_o, ready_o}), 1);

    run_txn(7'h6B, 1'b1, 1, -1, -1, 8);  // single read byte gets NACK
    chk(!od_bad && !scl_o && !sda_o, "R10", "output values stay low",
        int'(od_bad), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule